// File: doc/BRIEF.md
# DAC Output Channel Router

The router sits in front of a bank of digital-to-analog converters. It takes one left/right sample pair for each converter and decides which input each of the converter's two outputs carries. It can also flip the sign of either output. Each converter lane has four static control bits: mono, select, invert-left and invert-right. These bits combine freely, which gives sixteen routing cases for every lane. The routed pairs for all lanes appear together, one clock after the input strobe.

In stereo mode (mono clear), select either passes the pair straight through or swaps the two sides. In mono mode, select picks one input, left or right, and both outputs carry it. Sign inversion is applied after routing, separately for each output side. Negating the most negative two's-complement code saturates instead of wrapping.

The control bits are taken into a shadow copy only on cycles without an input strobe. So every pair is routed with one consistent setting, even if software changes the bits while a burst of pairs is in flight.

Top module: `dac_out_router`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid, out_left and out_right become zero and every lane's shadow setting becomes stereo, no swap, no inversion. A strobe on the first edge after reset is routed with that default, whatever the control inputs are.
- R2: With the mono bit of a lane at 0, select 0 routes left input to left output and right input to right output; select 1 routes left input to right output and right input to left output.
- R3: With the mono bit of a lane at 1, select 0 puts the left input on both outputs and select 1 puts the right input on both outputs.
- R4: Invert-left negates the routed left output and invert-right negates the routed right output, each in two's complement and independent of the other, applied after the R2/R3 routing.
- R5: Negating the most negative code (only the sign bit set) gives the most positive code (all bits set except the sign bit).
- R6: Control inputs are captured at a rising edge only when in_valid is low. A pair strobed in the same cycle as a control change, or in a run of back-to-back strobes, uses the setting captured before the strobe.
- R7: out_valid is high for exactly the cycle after each cycle in which in_valid is high. The output samples change only at edges where in_valid is high and hold otherwise.
- R8: Each lane i uses only its own bit i of cfg_mono, cfg_sel, cfg_inv_l and cfg_inv_r, and its own sample slice [i*SAMPLE_W +: SAMPLE_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: an input pair for every lane is present |
| in_left | input | NUM_DAC*SAMPLE_W | Left input samples, lane i in slice i, two's complement |
| in_right | input | NUM_DAC*SAMPLE_W | Right input samples, lane i in slice i, two's complement |
| cfg_mono | input | NUM_DAC | Per-lane mono enable |
| cfg_sel | input | NUM_DAC | Per-lane select: swap in stereo, source side in mono |
| cfg_inv_l | input | NUM_DAC | Per-lane left output negate |
| cfg_inv_r | input | NUM_DAC | Per-lane right output negate |
| out_valid | output | 1 | Routed pairs present, one clock after in_valid |
| out_left | output | NUM_DAC*SAMPLE_W | Routed left output samples |
| out_right | output | NUM_DAC*SAMPLE_W | Routed right output samples |

## Verification
The collision that matters is a control change arriving in the same cycle as a sample strobe. The bench provokes it by driving a new setting on the strobe cycle, and again in the second of two back-to-back strobes. Both pairs must come out routed with the setting captured before the strobe, and the new setting must show only after an idle cycle. Saturating negation is pushed into the same cycles by putting the most negative code on both sides while every one of the sixteen routing cases is swept across the lanes.

// File: rtl/dacr_pkg.sv
// Package: shared types for the DAC output channel router.
// Assumes two's-complement samples and one control set per lane.
package dacr_pkg;

    // Per-lane routing setting after shadow capture.
    typedef struct packed {
        logic mono;
        logic sel;
        logic inv_l;
        logic inv_r;
    } lane_cfg_t;

endpackage

// File: rtl/dacr_cfg_shadow.sv
// Module: dacr_cfg_shadow
// Holds a shadow copy of every lane's control bits. Loads only on cycles
// without a sample strobe, so a pair never sees a half-updated setting.
// Assumes the control inputs are synchronous to clk.
module dacr_cfg_shadow #(
    parameter int NUM_DAC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [NUM_DAC-1:0] cfg_mono,
    input  logic [NUM_DAC-1:0] cfg_sel,
    input  logic [NUM_DAC-1:0] cfg_inv_l,
    input  logic [NUM_DAC-1:0] cfg_inv_r,
    output logic [NUM_DAC-1:0] mono_q,
    output logic [NUM_DAC-1:0] sel_q,
    output logic [NUM_DAC-1:0] inv_l_q,
    output logic [NUM_DAC-1:0] inv_r_q
);

    // Capture controls while idle, freeze them during strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mono_q  <= '0;
            sel_q   <= '0;
            inv_l_q <= '0;
            inv_r_q <= '0;
        end else if (!in_valid) begin
            mono_q  <= cfg_mono;
            sel_q   <= cfg_sel;
            inv_l_q <= cfg_inv_l;
            inv_r_q <= cfg_inv_r;
        end
    end

endmodule

// File: rtl/dacr_sat_neg.sv
// Module: dacr_sat_neg
// Optional two's-complement negation that saturates the most negative
// code to the most positive one. Purely combinational.
module dacr_sat_neg #(
    parameter int W = 24
) (
    input  logic         en,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    // Pass, negate, or clamp the single overflow case.
    always_comb begin
        if (!en)
            y = x;
        else if (x == MOST_NEG)
            y = MOST_POS;
        else
            y = (~x) + ONE;
    end

endmodule

// File: rtl/dacr_lane.sv
// Module: dacr_lane
// Routing for one DAC lane: stereo pass/swap or mono duplicate, then
// independent saturating negation of each output side. Combinational.
module dacr_lane
    import dacr_pkg::*;
#(
    parameter int W = 24
) (
    input  lane_cfg_t    cfg,
    input  logic [W-1:0] in_l,
    input  logic [W-1:0] in_r,
    output logic [W-1:0] out_l,
    output logic [W-1:0] out_r
);

    logic [W-1:0] pick_l;
    logic [W-1:0] pick_r;

    // Choose the source of each output side from mono and select.
    always_comb begin
        if (cfg.mono) begin
            pick_l = cfg.sel ? in_r : in_l;
            pick_r = pick_l;
        end else begin
            pick_l = cfg.sel ? in_r : in_l;
            pick_r = cfg.sel ? in_l : in_r;
        end
    end

    dacr_sat_neg #(.W(W)) u_neg_l (.en(cfg.inv_l), .x(pick_l), .y(out_l));
    dacr_sat_neg #(.W(W)) u_neg_r (.en(cfg.inv_r), .x(pick_r), .y(out_r));

endmodule

// File: rtl/dac_out_router.sv
// Module: dac_out_router (top)
// Routes NUM_DAC left/right sample pairs to DAC output channels with a
// single register stage. Controls pass through a strobe-aware shadow.
// Assumes in_valid marks cycles on which all lanes carry a new pair.
module dac_out_router
    import dacr_pkg::*;
#(
    parameter int NUM_DAC  = 4,
    parameter int SAMPLE_W = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [NUM_DAC*SAMPLE_W-1:0] in_left,
    input  logic [NUM_DAC*SAMPLE_W-1:0] in_right,
    input  logic [NUM_DAC-1:0]          cfg_mono,
    input  logic [NUM_DAC-1:0]          cfg_sel,
    input  logic [NUM_DAC-1:0]          cfg_inv_l,
    input  logic [NUM_DAC-1:0]          cfg_inv_r,
    output logic                        out_valid,
    output logic [NUM_DAC*SAMPLE_W-1:0] out_left,
    output logic [NUM_DAC*SAMPLE_W-1:0] out_right
);

    localparam int BUS_W = NUM_DAC * SAMPLE_W;

    logic [NUM_DAC-1:0] mono_q;
    logic [NUM_DAC-1:0] sel_q;
    logic [NUM_DAC-1:0] inv_l_q;
    logic [NUM_DAC-1:0] inv_r_q;
    logic [BUS_W-1:0]   routed_l;
    logic [BUS_W-1:0]   routed_r;

    dacr_cfg_shadow #(.NUM_DAC(NUM_DAC)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .cfg_mono (cfg_mono),
        .cfg_sel  (cfg_sel),
        .cfg_inv_l(cfg_inv_l),
        .cfg_inv_r(cfg_inv_r),
        .mono_q   (mono_q),
        .sel_q    (sel_q),
        .inv_l_q  (inv_l_q),
        .inv_r_q  (inv_r_q)
    );

    for (genvar g = 0; g < NUM_DAC; g++) begin : g_lane
        lane_cfg_t lcfg;
        assign lcfg = '{mono: mono_q[g], sel: sel_q[g],
                        inv_l: inv_l_q[g], inv_r: inv_r_q[g]};
        dacr_lane #(.W(SAMPLE_W)) u_lane (
            .cfg  (lcfg),
            .in_l (in_left [g*SAMPLE_W +: SAMPLE_W]),
            .in_r (in_right[g*SAMPLE_W +: SAMPLE_W]),
            .out_l(routed_l[g*SAMPLE_W +: SAMPLE_W]),
            .out_r(routed_r[g*SAMPLE_W +: SAMPLE_W])
        );
    end

    // Register the routed pairs on each strobe and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= routed_l;
                out_right <= routed_r;
            end
        end
    end

endmodule

// File: rtl/dac_out_router_chk.sv
// Module: dac_out_router_chk
// Property checker for dac_out_router, attached by bind below.
module dac_out_router_chk #(
    parameter int NUM_DAC  = 4,
    parameter int SAMPLE_W = 24
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        out_valid,
    input logic [NUM_DAC*SAMPLE_W-1:0] out_left,
    input logic [NUM_DAC*SAMPLE_W-1:0] out_right,
    input logic [NUM_DAC-1:0]          mono_q,
    input logic [NUM_DAC-1:0]          sel_q,
    input logic [NUM_DAC-1:0]          inv_l_q,
    input logic [NUM_DAC-1:0]          inv_r_q
);

    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right))); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($stable(mono_q) && $stable(sel_q) && $stable(inv_l_q) && $stable(inv_r_q))); // R6

    for (genvar g = 0; g < NUM_DAC; g++) begin : g_chk
        AST_MONO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mono_q[g] && (inv_l_q[g] == inv_r_q[g]))
            |=> (out_left[g*SAMPLE_W +: SAMPLE_W] == out_right[g*SAMPLE_W +: SAMPLE_W])); // R3
        AST_NO_MIN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && inv_l_q[g]) |=> (out_left[g*SAMPLE_W +: SAMPLE_W] != MOST_NEG)); // R5
        AST_NO_MIN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && inv_r_q[g]) |=> (out_right[g*SAMPLE_W +: SAMPLE_W] != MOST_NEG)); // R5
    end

endmodule

bind dac_out_router dac_out_router_chk #(.NUM_DAC(NUM_DAC), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_left (out_left),
    .out_right(out_right),
    .mono_q   (mono_q),
    .sel_q    (sel_q),
    .inv_l_q  (inv_l_q),
    .inv_r_q  (inv_r_q)
);

// File: tb/dac_out_router_tb.sv
module dac_out_router_tb;

    localparam int N = 4;
    localparam int W = 24;
    localparam int MAXV = (1 << (W - 1)) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [N*W-1:0] in_left, in_right;
    logic [N-1:0] cfg_mono, cfg_sel, cfg_inv_l, cfg_inv_r;
    logic         out_valid;
    logic [N*W-1:0] out_left, out_right;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit e_mono [N];
    bit e_sel  [N];
    bit e_il   [N];
    bit e_ir   [N];

    always #5 clk = ~clk;

    dac_out_router #(.NUM_DAC(N), .SAMPLE_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .cfg_mono(cfg_mono), .cfg_sel(cfg_sel),
        .cfg_inv_l(cfg_inv_l), .cfg_inv_r(cfg_inv_r),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic logic [W-1:0] pat(int p, int i, bit right);
        int v;
        case (p)
            0: v = right ? MAXV : -(MAXV + 1);
            1: v = right ? -1 : 0;
            2: v = right ? (i * 4321 - 70000) : (i * 9999 + 12345);
            default: v = right ? -(MAXV + 1) : -MAXV;
        endcase
        return v[W-1:0];
    endfunction

    function automatic logic [W-1:0] neg_model(logic [W-1:0] x, bit en);
        int s;
        s = int'($signed(x));
        if (!en) return x;
        s = -s;
        if (s > MAXV) s = MAXV;
        return s[W-1:0];
    endfunction

    task automatic drive_cfg(int base);
        for (int i = 0; i < N; i++) begin
            int c = (base + 5 * i) % 16;
            cfg_mono[i]  = c[3];
            cfg_sel[i]   = c[2];
            cfg_inv_l[i] = c[1];
            cfg_inv_r[i] = c[0];
        end
    endtask

    task automatic set_exp(int base);
        for (int i = 0; i < N; i++) begin
            int c = (base + 5 * i) % 16;
            e_mono[i] = c[3]; e_sel[i] = c[2]; e_il[i] = c[1]; e_ir[i] = c[0];
        end
    endtask

    task automatic check(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_pair(int p);
        for (int i = 0; i < N; i++) begin
            in_left [i*W +: W] = pat(p, i, 1'b0);
            in_right[i*W +: W] = pat(p, i, 1'b1);
        end
        in_valid = 1'b1;
    endtask

    // Lane checks against the model; R2/R3 routing, R4/R5 negation, R8 per lane.
    task automatic check_lanes(int p);
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] l, r, sl, sr, el, er;
            string rq;
            l = pat(p, i, 1'b0);
            r = pat(p, i, 1'b1);
            if (e_mono[i]) begin sl = e_sel[i] ? r : l; sr = sl; rq = "R3/R8"; end
            else begin sl = e_sel[i] ? r : l; sr = e_sel[i] ? l : r; rq = "R2/R8"; end
            el = neg_model(sl, e_il[i]);
            er = neg_model(sr, e_ir[i]);
            if (e_il[i] || e_ir[i]) rq = {rq, "/R4/R5"};
            check(out_left[i*W +: W] == el, rq, $sformatf("lane%0d left", i), out_left[i*W +: W], el);
            check(out_right[i*W +: W] == er, rq, $sformatf("lane%0d right", i), out_right[i*W +: W], er);
        end
    endtask

    // Strobe one pair at the current negedge, check it, then check hold (R7).
    task automatic send_pair(int p);
        logic [N*W-1:0] hl, hr;
        drive_pair(p);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R7", "valid after strobe", {23'b0, out_valid}, 1);
        check_lanes(p);
        hl = out_left; hr = out_right;
        for (int i = 0; i < N; i++) begin
            in_left[i*W +: W] = ~pat(p, i, 1'b0);
            in_right[i*W +: W] = ~pat(p, i, 1'b1);
        end
        @(posedge clk); @(negedge clk);
        check(out_valid == 1'b0, "R7", "valid idle", {23'b0, out_valid}, 0);
        check(out_left == hl && out_right == hr, "R7", "data hold", out_left[W-1:0], hl[W-1:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_left = '1; in_right = '1;
        cfg_mono = '1; cfg_sel = '1; cfg_inv_l = '1; cfg_inv_r = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared by reset
        check(out_valid == 1'b0, "R1", "reset valid", {23'b0, out_valid}, 0);
        check(out_left == '0, "R1", "reset left", out_left[W-1:0], 0);
        check(out_right == '0, "R1", "reset right", out_right[W-1:0], 0);
        // R1: first strobe after reset uses default setting despite all-ones controls
        rst_n = 1'b1;
        set_exp(0);
        for (int i = 0; i < N; i++) begin e_mono[i] = 0; e_sel[i] = 0; e_il[i] = 0; e_ir[i] = 0; end
        send_pair(2);

        // Sweep all sixteen cases per lane, lanes offset from each other (R2-R5, R8)
        for (int b = 0; b < 16; b++) begin
            drive_cfg(b); set_exp(b);
            @(posedge clk); @(negedge clk);
            for (int p = 0; p < 4; p++) send_pair(p);
        end

        // R6: control change on the strobe cycle and during back-to-back strobes
        drive_cfg(3); set_exp(3);
        @(posedge clk); @(negedge clk);
        drive_cfg(9); drive_pair(0);
        @(posedge clk); @(negedge clk);
        check(out_valid == 1'b1, "R6", "collide valid", {23'b0, out_valid}, 1);
        check_lanes(0);
        drive_cfg(12); drive_pair(3);
        @(posedge clk); @(negedge clk);
        check(out_valid == 1'b1, "R6", "back-to-back valid", {23'b0, out_valid}, 1);
        check_lanes(3);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        set_exp(12);
        send_pair(0);
        send_pair(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule